// File: doc/BRIEF.md
# Interleaved Multithreaded Issue Scheduler

This block decides, on every clock cycle, which hardware thread sends its next instruction into one in-order scalar integer pipeline. A fixed pool of threads belongs to the pipeline. Each thread has a small instruction buffer in front of it. For each thread the scheduler sees whether the buffer holds an instruction and the decode class of that instruction. It grants at most one thread per cycle, rotating round-robin over the threads that are ready. When no thread can go, the cycle is a bubble.

Two kinds of long operation are handled in different ways. An operation with a fixed, known latency is recognised from its decode class. It loads a per-thread wait counter, and the thread is not granted again until the result is due. A load never blocks its thread. If the load later turns out to miss, a miss report for that thread kills every in-flight stage that carries that thread's tag. The same report parks the thread until a fill pulse with its id comes back. Stages that belong to other threads are left alone. A small shift register of stage tags follows the instructions down the pipeline, so the block can work out which stages to kill.

Top module: `vmt_issue_sched`

## Requirements
- R1: After reset `iss_vld` is low, every bit of `pipe_vld` is zero and `kill` is zero.
- R2: A thread is granted only when its `buf_vld` bit is set, it is not parked and its wait counter is zero. At most one thread is granted per cycle. When no thread qualifies, `iss_vld` stays low for that cycle (a bubble).
- R3: Ready threads are granted round-robin, starting at the thread after the most recently granted one. Right after reset the search starts at thread 0.
- R4: The decode class is two bits per thread at `buf_cls[2t+1:2t]`. Code 2 is a fixed-latency operation of `LAT_S` cycles and code 3 is one of `LAT_L` cycles. A thread granted such an operation in cycle c is not granted in cycles c+1 to c+LAT-1, and it is eligible again in cycle c+LAT.
- R5: Class code 1 (load) and class code 0 (simple) do not block their thread. The thread may be granted again in the very next cycle.
- R6: In a cycle with `miss_vld` high, `kill[i]` is set for exactly those stages i that are valid and tagged with `miss_tid`. On the next edge those stages become invalid, while stages of other threads advance unchanged.
- R7: A thread named by a miss report is not granted in the miss cycle. It stays parked until a `fill_vld` pulse carrying its id, and it is eligible again in the cycle after that pulse.
- R8: A grant in cycle c puts the thread id into stage 0 (`pipe_vld[0]`, `pipe_tid[2:0]` with the default parameters) at the next edge. Each later edge moves it one stage further, and it drops out after the last stage.
- R9: A fill pulse for a thread that is not parked has no effect. In particular it does not shorten a fixed-latency wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_vld | input | NTHR | Per-thread flag: the instruction buffer holds an instruction |
| buf_cls | input | 2*NTHR | Per-thread decode class of the buffer head (0 simple, 1 load, 2 short fixed, 3 long fixed) |
| miss_vld | input | 1 | A load of thread `miss_tid` has missed |
| miss_tid | input | TW | Thread id of the missing load |
| fill_vld | input | 1 | Miss data has returned for thread `fill_tid` |
| fill_tid | input | TW | Thread id of the returning fill |
| iss_vld | output | 1 | A thread is granted this cycle |
| iss_tid | output | TW | Granted thread id |
| iss_cls | output | 2 | Decode class of the granted instruction |
| pipe_vld | output | STAGES | Valid bit of each in-flight stage |
| pipe_tid | output | STAGES*TW | Thread tag of each in-flight stage |
| kill | output | STAGES | Per-stage kill vector for the current miss report |

## Verification
A wrong round-robin pointer shows up in the very next grant as a thread out of order, so the bench compares every cycle of a sequence and not only the totals. A wait counter that is loaded with the wrong value or decremented wrongly moves the first grant after a fixed-latency operation by one or more cycles, and that cycle is checked exactly. A wrong park flag or wrong stage tag shows up either in the kill vector of the miss cycle, in `pipe_vld` one edge later, or as the parked thread being granted before its fill.

// File: rtl/vmt_issue_sched.sv
module vmt_issue_sched #(
  parameter int NTHR   = 8,
  parameter int STAGES = 6,
  parameter int LAT_S  = 3,
  parameter int LAT_L  = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW = $clog2(LAT_L + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR-1:0]       buf_vld,
  input  logic [2*NTHR-1:0]     buf_cls,
  input  logic                  miss_vld,
  input  logic [TW-1:0]         miss_tid,
  input  logic                  fill_vld,
  input  logic [TW-1:0]         fill_tid,
  output logic                  iss_vld,
  output logic [TW-1:0]         iss_tid,
  output logic [1:0]            iss_cls,
  output logic [STAGES-1:0]     pipe_vld,
  output logic [STAGES*TW-1:0]  pipe_tid,
  output logic [STAGES-1:0]     kill
);

  logic [NTHR-1:0] parked;
  logic [NTHR-1:0] busy;
  logic [NTHR-1:0] miss_hit;
  logic [NTHR-1:0] fill_hit;
  logic [NTHR-1:0] ready;
  logic [TW-1:0]   last;
  logic [CW-1:0]   wcnt [NTHR];
  logic [TW-1:0]   stag [STAGES];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign miss_hit[t] = miss_vld && (miss_tid == TW'(t));
    assign fill_hit[t] = fill_vld && (fill_tid == TW'(t));
    assign busy[t]     = (wcnt[t] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wcnt[t]   <= '0;
        parked[t] <= 1'b0;
      end else begin
        if (iss_vld && iss_tid == TW'(t) && iss_cls[1])
          wcnt[t] <= iss_cls[0] ? CW'(LAT_L - 1) : CW'(LAT_S - 1);
        else if (busy[t])
          wcnt[t] <= wcnt[t] - 1'b1;
        if (miss_hit[t])
          parked[t] <= 1'b1;
        else if (fill_hit[t])
          parked[t] <= 1'b0;
      end
    end
  end

  assign ready = buf_vld & ~parked & ~busy & ~miss_hit;

  always_comb begin
    int j;
    iss_vld = 1'b0;
    iss_tid = '0;
    for (int k = 1; k <= NTHR; k++) begin
      j = int'(last) + k;
      if (j >= NTHR) j = j - NTHR;
      if (!iss_vld && ready[j]) begin
        iss_vld = 1'b1;
        iss_tid = TW'(j);
      end
    end
  end

  assign iss_cls = buf_cls[iss_tid*2 +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n)       last <= TW'(NTHR - 1);
    else if (iss_vld) last <= iss_tid;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    assign kill[s]               = pipe_vld[s] && miss_vld && (stag[s] == miss_tid);
    assign pipe_tid[s*TW +: TW]  = stag[s];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pipe_vld[s] <= 1'b0;
        stag[s]     <= '0;
      end else if (s == 0) begin
        pipe_vld[s] <= iss_vld;
        stag[s]     <= iss_tid;
      end else begin
        pipe_vld[s] <= pipe_vld[s-1] && !kill[s-1];
        stag[s]     <= stag[s-1];
      end
    end
  end

endmodule

// File: rtl/vmt_issue_sched_chk.sv
module vmt_issue_sched_chk #(
  parameter int NTHR = 8,
  parameter int STAGES = 6,
  parameter int TW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NTHR-1:0]      buf_vld,
  input logic                 miss_vld,
  input logic [TW-1:0]        miss_tid,
  input logic                 iss_vld,
  input logic [TW-1:0]        iss_tid,
  input logic [1:0]           iss_cls,
  input logic [STAGES-1:0]    pipe_vld,
  input logic [STAGES*TW-1:0] pipe_tid,
  input logic [STAGES-1:0]    kill,
  input logic [NTHR-1:0]      parked
);
  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n;

  a_r2_grant_has_instr: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |-> buf_vld[iss_tid]);

  a_r7_parked_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld |-> !parked[iss_tid]);

  a_r4_fixed_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(iss_vld && iss_cls[1])) |-> !(iss_vld && iss_tid == $past(iss_tid)));

  a_r6_kill_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (kill & ~pipe_vld) == '0);

  a_r6_flushed_gone: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> !(pipe_vld[0] && pipe_tid[TW-1:0] == $past(miss_tid)));
endmodule

bind vmt_issue_sched vmt_issue_sched_chk #(.NTHR(NTHR), .STAGES(STAGES), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .buf_vld(buf_vld), .miss_vld(miss_vld), .miss_tid(miss_tid),
  .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_cls(iss_cls), .pipe_vld(pipe_vld),
  .pipe_tid(pipe_tid), .kill(kill), .parked(parked)
);

// File: tb/vmt_issue_sched_tb.sv
module vmt_issue_sched_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  buf_vld;
  logic [15:0] buf_cls;
  logic        miss_vld, fill_vld;
  logic [2:0]  miss_tid, fill_tid;
  logic        iss_vld;
  logic [2:0]  iss_tid;
  logic [1:0]  iss_cls;
  logic [5:0]  pipe_vld, kill;
  logic [17:0] pipe_tid;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  vmt_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n), .buf_vld(buf_vld), .buf_cls(buf_cls),
    .miss_vld(miss_vld), .miss_tid(miss_tid), .fill_vld(fill_vld), .fill_tid(fill_tid),
    .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_cls(iss_cls),
    .pipe_vld(pipe_vld), .pipe_tid(pipe_tid), .kill(kill)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic grant(input string req, input bit ev, input int et);
    #1;
    check({req, " iss_vld"}, int'(iss_vld), int'(ev));
    if (ev) check({req, " iss_tid"}, int'(iss_tid), et);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; buf_vld = '0; buf_cls = '0;
    miss_vld = 0; miss_tid = 0; fill_vld = 0; fill_tid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 iss_vld", int'(iss_vld), 0);
    check("R1 pipe_vld", int'(pipe_vld), 0);
    check("R1 kill", int'(kill), 0);
    @(negedge clk);
    grant("R2 bubble", 0, 0);
  endtask

  task automatic t_rr_full();
    do_reset();
    buf_vld = 8'hFF;
    for (int k = 0; k < 9; k++) grant("R3 full rotation", 1, k % 8);
  endtask

  task automatic t_rr_sparse();
    do_reset();
    buf_vld = 8'b1010_0100;
    grant("R3 sparse", 1, 2);
    grant("R3 sparse", 1, 5);
    grant("R3 sparse", 1, 7);
    #1;
    check("R8 stage0 tid", int'(pipe_tid[2:0]), 7);
    check("R8 stage1 tid", int'(pipe_tid[5:3]), 5);
    check("R8 stage2 tid", int'(pipe_tid[8:6]), 2);
    check("R8 stage valid", int'(pipe_vld), 6'b000111);
    grant("R3 sparse wrap", 1, 2);
  endtask

  task automatic t_fixed(input int cls, input int lat, input bit with_fill);
    do_reset();
    buf_vld = 8'b0000_1000;
    buf_cls[7:6] = 2'(cls);
    grant("R4 first grant", 1, 3);
    for (int c = 1; c < lat; c++) begin
      if (with_fill && c == 1) begin fill_vld = 1; fill_tid = 3; end
      grant(with_fill ? "R9 fill no effect" : "R4 wait", 0, 0);
      fill_vld = 0;
    end
    grant("R4 eligible at c+LAT", 1, 3);
  endtask

  task automatic t_load();
    do_reset();
    buf_vld = 8'b0000_0100;
    buf_cls[5:4] = 2'd1;
    for (int k = 0; k < 4; k++) grant("R5 load no block", 1, 2);
  endtask

  task automatic t_miss();
    do_reset();
    buf_vld = 8'b0000_1111;
    for (int k = 0; k < 4; k++) grant("R3 pre-miss", 1, k);
    miss_vld = 1; miss_tid = 1;
    #1;
    check("R6 kill vector", int'(kill), 6'b000100);
    grant("R7 miss cycle", 1, 0);
    miss_vld = 0;
    #1;
    check("R6 pipe after flush", int'(pipe_vld), 6'b010111);
    check("R6 stage2 other thread", int'(pipe_tid[8:6]), 2);
    grant("R7 parked", 1, 2);
    grant("R7 parked", 1, 3);
    grant("R7 parked", 1, 0);
    fill_vld = 1; fill_tid = 1;
    grant("R7 fill cycle", 1, 2);
    fill_vld = 0;
    grant("R7 after fill", 1, 3);
    grant("R7 after fill", 1, 0);
    grant("R7 re-issue", 1, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rr_full();
    t_rr_sparse();
    t_fixed(3, 8, 0);
    t_fixed(2, 3, 0);
    t_fixed(3, 8, 1);
    t_load();
    t_miss();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule